// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block is a synchronous master for an external asynchronous read-only memory whose data bus can be strapped per access to either 16-bit words or 8-bit bytes. A host hands it one read at a time over a valid/ready handshake, with an address and a width flag. The sequencer then pulls the memory's active-low chip enable and output enable, drives the address and the width select, and holds everything steady for a number of clocks derived from the clock period and the memory's access time. It samples the data bus on the last of those clocks and returns the result with a one-cycle valid pulse.

In byte mode the memory's top data pin turns into the lowest address input. The sequencer therefore splits the host byte address into a word-line address and a half-select bit, drives that bit out on its own pin with an enable, and returns only the low data lane, zero-extended. The memory releases its data drivers only some time after a word read ends. For that reason, a byte read that follows a word read waits out a bus turnaround before the half-select pin is driven. Whenever no read is in progress the chip enable is high, so the memory stays in standby.

Top module: `romReadSeq`

## Requirements
- R1: After reset, romCeN and romOeN are 1, reqReady is 1, rspValid is 0, romA1Drive is 0 and romByteN is 1.
- R2: A read is accepted on a clock edge where reqValid and reqReady are both 1. reqReady stays 0 from the cycle after acceptance until the response cycle, so only one read is outstanding.
- R3: For each read, romCeN and romOeN are low together for exactly WAIT_CYC = ceil(ACCESS_NS / CLK_NS) consecutive clocks (23 by default), and romAddr and romA1Out do not change while romCeN is low.
- R4: The data bus is sampled on the last low clock. rspValid is 1 for exactly the one cycle after it, and with no turnaround the response comes WAIT_CYC + 1 cycles after the accepting edge.
- R5: Word mode (reqByteMode = 0): romByteN is 1, romAddr = reqAddr[22:0] (bit 23 is ignored), romA1Drive is 0, and rspData carries all 16 data lines.
- R6: Byte mode (reqByteMode = 1): romByteN is 0, romAddr = reqAddr[23:1], romA1Out = reqAddr[0], and romA1Drive is 1 only while romCeN is low.
- R7: In byte mode rspData[7:0] = romDataIn[7:0] and rspData[15:8] = 0, whatever lines 8 to 15 carry.
- R8: A byte read that follows a word read pulls romCeN low only after romCeN has been high for at least TURN_CYC = ceil(DISABLE_NS / CLK_NS) clocks (5 by default). Other mode sequences lose no cycles to turnaround.
- R9: romCeN is high whenever no read is in progress, including while reqReady is 1, and at least one clock separates two reads.
- R10: romOeN is never low while romCeN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host read request |
| reqReady | output | 1 | Sequencer can accept a request |
| reqAddr | input | 24 | Byte address (byte mode) or word address in bits 22:0 (word mode) |
| reqByteMode | input | 1 | 1 selects an 8-bit access, 0 a 16-bit access |
| rspValid | output | 1 | One-cycle pulse marking returned data |
| rspData | output | 16 | Returned data, zero-extended in byte mode |
| romCeN | output | 1 | Memory chip enable, active low |
| romOeN | output | 1 | Memory output enable, active low |
| romByteN | output | 1 | Memory width select, low for byte access |
| romAddr | output | 23 | Memory word-line address |
| romA1Out | output | 1 | Half-select address bit for byte access |
| romA1Drive | output | 1 | Enable for driving romA1Out onto the shared data pin |
| romDataIn | input | 16 | Memory data bus |

## Verification
The bench models the memory so that it shows garbage until the address and width select have been held for the full access time. A sequencer that samples one clock early, or that lets the address move during a read, returns wrong data. The bench issues a byte read straight after a word read and measures how long the chip enable stays high. A design that skips the turnaround starts the byte read after a single idle clock. The bench also times byte-after-byte and delayed word-to-byte reads, which catch a design that stalls where no turnaround is needed. It fills the unused upper lane with a pattern and reads both halves of a word, so a missing zero extension, a swapped half-select or an undriven half-select pin all return the wrong byte.

// File: rtl/romSeqPkg.sv
package romSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TURN   = 2'd1,
    ST_ACCESS = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic capture;  // sample the data bus this edge
    logic busOn;    // memory selected and outputs enabled
  } seqStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/romSeqCtrl.sv
module romSeqCtrl
  import romSeqPkg::*;
#(
  parameter int WAIT_CYC = 23,
  parameter int TURN_CYC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqByteMode,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  localparam int WCW = $clog2(WAIT_CYC + 1);
  localparam int QCW = $clog2(TURN_CYC + 1);

  seqState_t       state, nextState;
  logic [WCW-1:0]  waitCnt;
  logic [QCW-1:0]  quietCnt;
  logic            lastWord;
  logic            curByte;
  logic            lastWait;
  logic            quietNextOk;

  assign lastWait    = (waitCnt == WCW'(WAIT_CYC - 1));
  assign quietNextOk = (32'(quietCnt) + 32'd1) >= 32'(TURN_CYC);

  assign reqReady        = (state == ST_IDLE);
  assign strobe.load     = (state == ST_IDLE) && reqValid;
  assign strobe.busOn    = (state == ST_ACCESS);
  assign strobe.capture  = (state == ST_ACCESS) && lastWait;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:
        if (reqValid) begin
          if (reqByteMode && lastWord && !quietNextOk) nextState = ST_TURN;
          else                                         nextState = ST_ACCESS;
        end
      ST_TURN:
        if (quietNextOk) nextState = ST_ACCESS;
      ST_ACCESS:
        if (lastWait) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      quietCnt <= QCW'(TURN_CYC);
      lastWord <= 1'b0;
      curByte  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_ACCESS && !lastWait) waitCnt <= waitCnt + 1'b1;
      else                                 waitCnt <= '0;
      if (state == ST_ACCESS)                  quietCnt <= '0;
      else if (quietCnt < QCW'(TURN_CYC))      quietCnt <= quietCnt + 1'b1;
      if (strobe.load)    curByte  <= reqByteMode;
      if (strobe.capture) lastWord <= !curByte;
    end
  end

endmodule

// File: rtl/romSeqDatapath.sv
module romSeqDatapath
  import romSeqPkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByteMode,
  input  logic [DATA_W-1:0] romDataIn,
  output logic              romCeN,
  output logic              romOeN,
  output logic              romByteN,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romA1Out,
  output logic              romA1Drive,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W:0]   addrQ;
  logic              byteQ;
  logic [DATA_W-1:0] dataQ;
  logic              rspQ;
  logic [DATA_W-1:0] laneWord;

  // low lane always passes, upper lane is masked in byte mode
  for (genvar i = 0; i < DATA_W; i++) begin : gLane
    if (i < LANE_W) begin : gLow
      assign laneWord[i] = romDataIn[i];
    end else begin : gHigh
      assign laneWord[i] = romDataIn[i] & ~byteQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      byteQ <= 1'b0;
      dataQ <= '0;
      rspQ  <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrQ <= reqAddr;
        byteQ <= reqByteMode;
      end
      if (strobe.capture) dataQ <= laneWord;
      rspQ <= strobe.capture;
    end
  end

  assign romCeN     = ~strobe.busOn;
  assign romOeN     = ~strobe.busOn;
  assign romByteN   = ~byteQ;
  assign romAddr    = byteQ ? addrQ[ADDR_W:1] : addrQ[ADDR_W-1:0];
  assign romA1Out   = addrQ[0];
  assign romA1Drive = byteQ & strobe.busOn;
  assign rspValid   = rspQ;
  assign rspData    = dataQ;

endmodule

// File: rtl/romReadSeq.sv
module romReadSeq
  import romSeqPkg::*;
#(
  parameter int CLK_NS     = 4,
  parameter int ACCESS_NS  = 90,
  parameter int DISABLE_NS = 20,
  parameter int ADDR_W     = 23,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByteMode,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              romCeN,
  output logic              romOeN,
  output logic              romByteN,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romA1Out,
  output logic              romA1Drive,
  input  logic [DATA_W-1:0] romDataIn
);

  localparam int WAIT_CYC = (ceilDiv(ACCESS_NS, CLK_NS) < 1) ? 1 : ceilDiv(ACCESS_NS, CLK_NS);
  localparam int TURN_CYC = (ceilDiv(DISABLE_NS, CLK_NS) < 1) ? 1 : ceilDiv(DISABLE_NS, CLK_NS);

  seqStrobe_t strobe;

  romSeqCtrl #(
    .WAIT_CYC(WAIT_CYC),
    .TURN_CYC(TURN_CYC)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqByteMode(reqByteMode),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  romSeqDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqByteMode(reqByteMode),
    .romDataIn  (romDataIn),
    .romCeN     (romCeN),
    .romOeN     (romOeN),
    .romByteN   (romByteN),
    .romAddr    (romAddr),
    .romA1Out   (romA1Out),
    .romA1Drive (romA1Drive),
    .rspValid   (rspValid),
    .rspData    (rspData)
  );

endmodule

// File: rtl/romReadSeqChk.sv
module romReadSeqChk #(
  parameter int WAIT_CYC = 23,
  parameter int TURN_CYC = 5,
  parameter int ADDR_W   = 23,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              romCeN,
  input logic              romOeN,
  input logic              romByteN,
  input logic [ADDR_W-1:0] romAddr,
  input logic              romA1Out,
  input logic              romA1Drive
);

  int unsigned ceLowCnt;
  int unsigned ceHighCnt;
  logic        prevWasWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceLowCnt    <= 0;
      ceHighCnt   <= TURN_CYC;
      prevWasWord <= 1'b0;
    end else begin
      ceLowCnt <= romCeN ? 0 : ceLowCnt + 1;
      if (!romCeN)                ceHighCnt <= 0;
      else if (ceHighCnt < TURN_CYC) ceHighCnt <= ceHighCnt + 1;
      if (!romCeN) prevWasWord <= romByteN;
    end
  end

  // R2
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R3
  access_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romCeN) |-> ceLowCnt == WAIT_CYC);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !romCeN && $past(!romCeN) |-> $stable(romAddr) && $stable(romA1Out));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!romCeN) && romCeN);

  // R4
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6
  a1_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    romA1Drive |-> !romCeN && !romByteN);

  // R7
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && $past(!romByteN) |-> rspData[DATA_W-1:DATA_W/2] == '0);

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(romCeN) && !romByteN && prevWasWord |-> ceHighCnt >= TURN_CYC);

  // R9
  standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> romCeN);

  // R10
  oe_under_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> !romCeN);

endmodule

bind romReadSeq romReadSeqChk #(
  .WAIT_CYC(WAIT_CYC),
  .TURN_CYC(TURN_CYC),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .rspValid   (rspValid),
  .rspData    (rspData),
  .romCeN     (romCeN),
  .romOeN     (romOeN),
  .romByteN   (romByteN),
  .romAddr    (romAddr),
  .romA1Out   (romA1Out),
  .romA1Drive (romA1Drive)
);

// File: tb/tb_romReadSeq.sv
`timescale 1ns/1ps
module tb_romReadSeq;

  localparam int CLK_NS  = 4;
  localparam int ACC_NS  = 90;
  localparam int DIS_NS  = 20;
  localparam int WAITC   = (ACC_NS + CLK_NS - 1) / CLK_NS;  // 23
  localparam int TURNC   = (DIS_NS + CLK_NS - 1) / CLK_NS;  // 5

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic        reqByteMode = 1'b0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        romCeN, romOeN, romByteN, romA1Out, romA1Drive;
  logic [22:0] romAddr;
  logic [15:0] romDataIn;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  romReadSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqByteMode(reqByteMode), .rspValid(rspValid),
    .rspData(rspData), .romCeN(romCeN), .romOeN(romOeN), .romByteN(romByteN),
    .romAddr(romAddr), .romA1Out(romA1Out), .romA1Drive(romA1Drive),
    .romDataIn(romDataIn)
  );

  // ---------------- memory model ----------------
  function automatic logic [15:0] memWord(input logic [22:0] a);
    return a[15:0] ^ {a[22:16], 9'h1B5};
  endfunction

  logic [24:0] prevKey;
  logic [24:0] curKey;
  int          accCycles;
  logic        active;
  assign curKey = {romByteN, romA1Out, romAddr};
  assign active = !romCeN && !romOeN;

  always @(posedge clk) begin
    prevKey <= curKey;
    if (active && curKey == prevKey) accCycles <= accCycles + 1;
    else if (active)                 accCycles <= 1;
    else                             accCycles <= 0;
  end

  always_comb begin
    if (!active || accCycles < WAITC - 1) romDataIn = 16'hBAD0;
    else if (romByteN)                    romDataIn = memWord(romAddr);
    else if (!romA1Drive)                 romDataIn = 16'h55EE;
    else if (romA1Out)                    romDataIn = {8'h55, memWord(romAddr)[15:8]};
    else                                  romDataIn = {8'h55, memWord(romAddr)[7:0]};
  end

  // ---------------- bus monitors ----------------
  int   ceHighRun = 100;
  int   ceLowRun  = 0;
  int   lastGap   = 0;
  int   lenBad    = 0;
  int   oeBad     = 0;
  int   a1Bad     = 0;
  logic prevCeN   = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (!romOeN && romCeN) oeBad++;
      if (romA1Drive && romCeN) a1Bad++;
      if (!romCeN) begin
        if (prevCeN) begin
          lastGap  = ceHighRun;
          ceLowRun = 0;
        end
        ceLowRun++;
        ceHighRun = 0;
      end else begin
        if (!prevCeN && ceLowRun != WAITC) lenBad++;
        ceHighRun++;
      end
      prevCeN = romCeN;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one read; starts and ends at a negedge, returns latency in cycles
  task automatic doRead(input logic [23:0] addr, input logic byteMode, input string tag,
                        output int latency);
    logic [15:0] exp;
    bit          seenBus;
    while (!reqReady) @(negedge clk);
    reqValid    = 1'b1;
    reqAddr     = addr;
    reqByteMode = byteMode;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R2 ready drops"}, reqReady, 1'b0);
    latency = 1;
    seenBus = 0;
    while (!rspValid) begin
      if (!romCeN && !seenBus) begin
        seenBus = 1;
        check({tag, " R5/R6 width select"}, romByteN, !byteMode);
        check({tag, " R5/R6 address"}, romAddr, byteMode ? addr[23:1] : addr[22:0]);
        check({tag, " R6 half-select drive"}, romA1Drive, byteMode);
        if (byteMode) check({tag, " R6 half-select value"}, romA1Out, addr[0]);
      end
      @(negedge clk);
      latency++;
    end
    if (byteMode) exp = {8'h00, addr[0] ? memWord(addr[23:1])[15:8] : memWord(addr[23:1])[7:0]};
    else          exp = memWord(addr[22:0]);
    check({tag, byteMode ? " R7 byte data" : " R5 word data"}, rspData, exp);
    check({tag, " R9 standby at response"}, romCeN, 1'b1);
    check({tag, " R2 ready at response"}, reqReady, 1'b1);
  endtask

  task automatic testReset();
    check("R1 ce", romCeN, 1'b1);
    check("R1 oe", romOeN, 1'b1);
    check("R1 ready", reqReady, 1'b1);
    check("R1 rsp", rspValid, 1'b0);
    check("R1 a1 drive", romA1Drive, 1'b0);
    check("R1 byte select", romByteN, 1'b1);
  endtask

  task automatic testWordReads();
    int lat;
    doRead(24'h000000, 1'b0, "word0", lat);
    check("R4 word latency", lat, WAITC + 1);
    @(negedge clk);
    check("R4 single pulse", rspValid, 1'b0);
    doRead(24'h812345, 1'b0, "wordHiBitIgnored", lat);  // bit 23 ignored (R5)
    doRead(24'h7FFFFF, 1'b0, "wordMax", lat);
    check("R9 gap word-word", lastGap, 1);
    check("R4 back-to-back latency", lat, WAITC + 1);
  endtask

  task automatic testByteReads();
    int lat;
    repeat (TURNC + 2) @(negedge clk);
    doRead(24'h00ABCD, 1'b1, "byteLow", lat);
    check("R8 no stall after idle", lat, WAITC + 1);
    doRead(24'h00ABCD | 24'h1, 1'b1, "byteHigh", lat);
    check("R8 byte-byte no stall", lat, WAITC + 1);
    doRead(24'hFFFFFF, 1'b1, "byteMax", lat);
  endtask

  task automatic testTurnaround();
    int lat;
    doRead(24'h012344, 1'b0, "wordBeforeByte", lat);
    doRead(24'h024689, 1'b1, "byteAfterWord", lat);
    check("R8 turnaround gap", lastGap >= TURNC, 1'b1);
    check("R8 turnaround latency", lat, WAITC + TURNC);
    doRead(24'h000010, 1'b0, "wordAfterByte", lat);
    check("R8 byte-word no stall", lat, WAITC + 1);
  endtask

  task automatic testStandby();
    repeat (10) begin
      @(negedge clk);
      check("R9 idle standby", romCeN, 1'b1);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testWordReads();
    testByteReads();
    testTurnaround();
    testStandby();
    check("R3 access length", lenBad, 0);
    check("R10 oe under ce", oeBad, 0);
    check("R6 drive only when selected", a1Bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule